// File: doc/BRIEF.md
# 8-bit ALU with Digit-Carry Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator core. It combines the working register value with a second operand, which comes either from a file register or from an immediate field. From these it forms an 8-bit result and a set of candidate status flags. Both are combinational and available in the same cycle as the inputs.

The status flags are Carry, Digit Carry and Zero. They live in a small register inside the block. Each operation has a fixed mask that names the flags it may change. An external per-flag enable narrows that mask further. When the update strobe is high, the masked flags are written at the next clock edge. Every other flag keeps its value.

Subtraction returns the file operand minus the working register. In a subtraction, Carry and Digit Carry hold the inverted borrow, so 1 means no borrow occurred. Writing the result to any destination is left to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: While rst_ni is low, and after it is released, flags_o reads 3'b000.
- R2: Op code 0 (add) gives result_o = (w_i + f_i) mod 256. Carry is the carry out of bit 7, and Digit Carry is the carry out of bit 3 into bit 4.
- R3: Op code 1 (subtract) gives result_o = (f_i - w_i) mod 256. Carry is 1 exactly when f_i >= w_i. Digit Carry is 1 exactly when f_i[3:0] >= w_i[3:0].
- R4: For op codes 0 to 7, Zero is 1 exactly when result_o is 8'h00.
- R5: Op codes 2, 3 and 4 give f_i AND, OR and XOR w_i. Op code 5 gives ~f_i and ignores w_i. These four change only Zero.
- R6: Op code 6 gives f_i + 1 and op code 7 gives f_i - 1, both wrapping modulo 256. They change only Zero.
- R7: Op code 8 gives {f_i[6:0], c_i} with Carry = f_i[7]. Op code 9 gives {c_i, f_i[7:1]} with Carry = f_i[0]. Both change only Carry.
- R8: Op code 10 returns f_i with its nibbles exchanged and changes no flag.
- R9: A flag whose bit in flag_en_i is 0 keeps its value in flags_nxt_o, even when the operation would change it.
- R10: Flag bit positions are: bit 0 Carry, bit 1 Digit Carry, bit 2 Zero. result_o and flags_nxt_o follow the inputs in the same cycle. flags_o takes flags_nxt_o at a rising edge where upd_i is 1 and holds otherwise.
- R11: Op codes 11 to 15 return f_i unchanged and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working register operand |
| f_i | input | 8 | File register or immediate operand |
| c_i | input | 1 | Carry input for the rotates |
| flag_en_i | input | 3 | Per-flag write enable {Z, DC, C} |
| upd_i | input | 1 | Commit flags_nxt_o into the flag register |
| result_o | output | 8 | Combinational result |
| flags_nxt_o | output | 3 | Combinational next flags {Z, DC, C} |
| flags_o | output | 3 | Registered flags {Z, DC, C} |

## Verification
result_o and flags_nxt_o depend on no register on the input path, so each is due in the cycle its inputs are applied. The bench drives inputs on the falling edge and samples both outputs one nanosecond later, before the next rising edge. flags_o changes one rising edge after an update, so it is read one nanosecond after that edge. A bench-side model of the flag register predicts the bits that a mask or enable leaves untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_SWAP = 4'd10
  } alu_op_e;

  localparam int unsigned NFLAGS = 3;
  localparam int unsigned FL_C   = 0;
  localparam int unsigned FL_DC  = 1;
  localparam int unsigned FL_Z   = 2;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         co_o,
  output logic         hc_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0]   opa;
  logic [NIB:0]   cin_ext;
  logic [NIB:0]   lo;
  logic [W-NIB:0] hi;
  logic [W-NIB:0] hc_ext;

  // b - a computed as b + ~a + 1; carries then mean "no borrow"
  assign opa     = sub_i ? ~a_i : a_i;
  assign cin_ext = {{NIB{1'b0}}, sub_i};
  assign lo      = {1'b0, b_i[NIB-1:0]} + {1'b0, opa[NIB-1:0]} + cin_ext;
  assign hc_ext  = {{(W-NIB){1'b0}}, lo[NIB]};
  assign hi      = {1'b0, b_i[W-1:NIB]} + {1'b0, opa[W-1:NIB]} + hc_ext;

  assign sum_o = {hi[W-NIB-1:0], lo[NIB-1:0]};
  assign co_o  = hi[W-NIB];
  assign hc_o  = lo[NIB];

  a_r2_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> ({co_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i})));
  a_r3_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> (co_o == (b_i >= a_i)) && (hc_o == (b_i[NIB-1:0] >= a_i[NIB-1:0])));
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int unsigned NIB = W / 2;

  always_comb begin
    cout_o = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = b_i & a_i;
      OP_OR:   res_o = b_i | a_i;
      OP_XOR:  res_o = b_i ^ a_i;
      OP_COM:  res_o = ~b_i;
      OP_INC:  res_o = b_i + W'(1);
      OP_DEC:  res_o = b_i - W'(1);
      OP_ROL: begin
        res_o  = {b_i[W-2:0], c_i};
        cout_o = b_i[W-1];
      end
      OP_ROR: begin
        res_o  = {c_i, b_i[W-1:1]};
        cout_o = b_i[0];
      end
      OP_SWAP: res_o = {b_i[NIB-1:0], b_i[W-1:NIB]};
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [NFLAGS-1:0] mask_i,
  input  logic [NFLAGS-1:0] en_i,
  input  logic [NFLAGS-1:0] new_i,
  output logic [NFLAGS-1:0] nxt_o,
  output logic [NFLAGS-1:0] q_o
);
  logic [NFLAGS-1:0] wmask;
  logic [NFLAGS-1:0] flags_q;

  assign wmask = mask_i & en_i;
  assign nxt_o = (new_i & wmask) | (flags_q & ~wmask);
  assign q_o   = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= nxt_o;
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_q));
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flags_q == $past(nxt_o));
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~en_i & (nxt_o ^ flags_q)) == '0));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      w_i,
  input  logic [W-1:0]      f_i,
  input  logic              c_i,
  input  logic [NFLAGS-1:0] flag_en_i,
  input  logic              upd_i,
  output logic [W-1:0]      result_o,
  output logic [NFLAGS-1:0] flags_nxt_o,
  output logic [NFLAGS-1:0] flags_o
);
  alu_op_e           op;
  logic              is_arith;
  logic [W-1:0]      sum;
  logic              co, hc;
  logic [W-1:0]      unit_res;
  logic              unit_co;
  logic [NFLAGS-1:0] mask;
  logic [NFLAGS-1:0] new_flags;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu8_arith #(.W(W)) u_arith (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sub_i (op == OP_SUB),
    .a_i   (w_i),
    .b_i   (f_i),
    .sum_o (sum),
    .co_o  (co),
    .hc_o  (hc)
  );

  alu8_unit #(.W(W)) u_unit (
    .op_i  (op),
    .a_i   (w_i),
    .b_i   (f_i),
    .c_i   (c_i),
    .res_o (unit_res),
    .cout_o(unit_co)
  );

  assign result_o = is_arith ? sum : unit_res;

  always_comb begin
    mask = '0;
    case (op)
      OP_ADD, OP_SUB:                mask = 3'b111;
      OP_AND, OP_OR, OP_XOR, OP_COM,
      OP_INC, OP_DEC:                mask[FL_Z] = 1'b1;
      OP_ROL, OP_ROR:                mask[FL_C] = 1'b1;
      default:                       mask = '0;
    endcase
  end

  always_comb begin
    new_flags        = '0;
    new_flags[FL_Z]  = (result_o == '0);
    new_flags[FL_DC] = hc;
    new_flags[FL_C]  = is_arith ? co : unit_co;
  end

  alu8_flags u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd_i),
    .mask_i(mask),
    .en_i  (flag_en_i),
    .new_i (new_flags),
    .nxt_o (flags_nxt_o),
    .q_o   (flags_o)
  );

  a_r4_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i < 4'd8 && flag_en_i[FL_Z]) |-> flags_nxt_o[FL_Z] == (result_o == '0));
  a_r7_rot_only_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd8 || op_i == 4'd9) |-> flags_nxt_o[FL_Z:FL_DC] == flags_o[FL_Z:FL_DC]);
  a_r8_swap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd10) |-> flags_nxt_o == flags_o);
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int NV = 20;
  // {op, w, f, c_in, result, flag mask, flags {Z,DC,C}}
  localparam logic [34:0] VEC [NV] = '{
    {4'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 3'b111, 3'b010},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 3'b111, 3'b111},
    {4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 3'b111, 3'b101},
    {4'd0,  8'h12, 8'h34, 1'b0, 8'h46, 3'b111, 3'b000},
    {4'd1,  8'h05, 8'h10, 1'b0, 8'h0B, 3'b111, 3'b001},
    {4'd1,  8'h20, 8'h10, 1'b0, 8'hF0, 3'b111, 3'b010},
    {4'd1,  8'h33, 8'h33, 1'b0, 8'h00, 3'b111, 3'b111},
    {4'd2,  8'hF0, 8'h0F, 1'b0, 8'h00, 3'b100, 3'b100},
    {4'd3,  8'hA0, 8'h05, 1'b0, 8'hA5, 3'b100, 3'b000},
    {4'd4,  8'hFF, 8'hFF, 1'b0, 8'h00, 3'b100, 3'b100},
    {4'd5,  8'hFF, 8'h5A, 1'b0, 8'hA5, 3'b100, 3'b000},
    {4'd6,  8'h00, 8'hFF, 1'b0, 8'h00, 3'b100, 3'b100},
    {4'd7,  8'h00, 8'h00, 1'b0, 8'hFF, 3'b100, 3'b000},
    {4'd7,  8'h00, 8'h01, 1'b0, 8'h00, 3'b100, 3'b100},
    {4'd8,  8'h00, 8'h81, 1'b0, 8'h02, 3'b001, 3'b001},
    {4'd8,  8'h00, 8'h40, 1'b1, 8'h81, 3'b001, 3'b000},
    {4'd9,  8'h00, 8'h01, 1'b1, 8'h80, 3'b001, 3'b001},
    {4'd9,  8'h00, 8'h02, 1'b0, 8'h01, 3'b001, 3'b000},
    {4'd10, 8'h00, 8'hA5, 1'b0, 8'h5A, 3'b000, 3'b000},
    {4'd12, 8'h00, 8'h3C, 1'b0, 8'h3C, 3'b000, 3'b000}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] w_i = '0, f_i = '0;
  logic       c_i = 1'b0;
  logic [2:0] flag_en_i = 3'b111;
  logic       upd_i = 1'b0;
  logic [7:0] result_o;
  logic [2:0] flags_nxt_o, flags_o;

  int n_chk = 0, n_fail = 0;
  logic [2:0] model_q = '0;

  always #4 clk_i = ~clk_i;

  alu8_core u_alu8_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .w_i(w_i), .f_i(f_i),
    .c_i(c_i), .flag_en_i(flag_en_i), .upd_i(upd_i), .result_o(result_o),
    .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                       input logic c, input logic [2:0] en, input logic upd);
    @(negedge clk_i);
    op_i = op; w_i = w; f_i = f; c_i = c; flag_en_i = en; upd_i = upd;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] wm, exp_nxt;
    #10;
    chk("R1 reset flags", {5'd0, flags_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", {5'd0, flags_o}, 8'h00);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R11, all enables set, update each step
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34:31], VEC[i][30:23], VEC[i][22:15], VEC[i][14], 3'b111, 1'b1);
      wm      = VEC[i][5:3];
      exp_nxt = (VEC[i][2:0] & wm) | (model_q & ~wm);
      chk($sformatf("R2-R8/R11 result vec%0d", i), result_o, VEC[i][13:6]);
      chk($sformatf("R4 flags_nxt vec%0d", i), {5'd0, flags_nxt_o}, {5'd0, exp_nxt});
      @(posedge clk_i); #1;
      model_q = exp_nxt;
      chk($sformatf("R10 flags_o vec%0d", i), {5'd0, flags_o}, {5'd0, model_q});
    end

    // R9: only Carry enabled; start from known 3'b000 via subtract
    apply(4'd1, 8'h01, 8'h00, 1'b0, 3'b111, 1'b1);     // 0-1: Z0 DC0 C0
    @(posedge clk_i); #1;
    chk("R9 setup", {5'd0, flags_o}, 8'h00);
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 3'b001, 1'b1);     // add would give 111
    chk("R9 gated nxt", {5'd0, flags_nxt_o}, 8'h01);
    @(posedge clk_i); #1;
    chk("R9 gated flags_o", {5'd0, flags_o}, 8'h01);

    // R10: no update keeps register
    apply(4'd0, 8'h00, 8'h00, 1'b0, 3'b111, 1'b0);     // nxt = 3'b100
    chk("R10 nxt same cycle", {5'd0, flags_nxt_o}, 8'h04);
    @(posedge clk_i); #1;
    chk("R10 hold without upd", {5'd0, flags_o}, 8'h01);

    // R5: COM ignores w
    apply(4'd5, 8'h3C, 8'h0F, 1'b0, 3'b111, 1'b0);
    chk("R5 com ignores w", result_o, 8'hF0);

    // R8: swap keeps flags set to 1
    apply(4'd1, 8'h07, 8'h07, 1'b0, 3'b111, 1'b1);
    @(posedge clk_i); #1;
    apply(4'd10, 8'h00, 8'h00, 1'b0, 3'b111, 1'b1);
    @(posedge clk_i); #1;
    chk("R8 swap keeps flags", {5'd0, flags_o}, 8'h07);

    // R1: reset mid-run clears flags
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1 async clear", {5'd0, flags_o}, 8'h00);
    upd_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule